// File: doc/BRIEF.md
# Programmable Clock-Gated Delay Line

The block delays a data word by a selectable number of register stages, from zero up to the number of stages built. A select mask with one bit per stage sets the length. A stage whose bit is set routes its input through its own register. A stage whose bit is clear steers its input around that register. That register is then never loaded, and its output is forced to zero so it cannot reach the path. The total delay is the number of set bits. Where the set bits sit in the mask makes no difference.

Data moves only on cycles where the advance strobe is high. The delay is therefore counted in strobes, not in clock cycles. A clock-enable on each stage register stands in for a real gated clock. When all bits are clear, the path is purely combinational from input to output. After the mask changes, the output settles to the new delay once as many strobes have passed as the new mask has set bits. That is never more than the stage count.

Top module: `dlp_delay_line`

## Requirements
- R1: With every select bit clear, `dout` equals `din` in the same cycle, with no strobe needed.
- R2: A stage whose select bit is clear passes its input to its output unchanged in the same cycle. Clearing only the last stage of an 8-stage line gives a delay of 7 strobes.
- R3: A stage whose select bit is set loads its input into its register on a clock edge where `en` is high. The stage output is then that register. Stage 0 is the one nearest `din`.
- R4: A stage whose select bit is clear does not load its register. When the bit is set again, the value held from the last load appears at the output before any new strobe.
- R5: Once the mask is settled, `dout` equals the `din` value presented k strobes earlier, where k is the number of set bits in `sel_mask`, whatever their positions.
- R6: With `en` low, no stage register changes. With at least one select bit set, `dout` then stays constant even while `din` changes.
- R7: A synchronous active-high `rst` clears every stage register to zero. With all bits set right after reset, `dout` is 0.
- R8: After the mask changes to a value with k set bits, the output is exact from the k-th strobe onward, and k is at most the stage count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance strobe; stage registers load only when high |
| sel_mask | input | STAGES (8) | One select bit per stage; bit 0 is nearest the input |
| din | input | WIDTH (16) | Data input |
| dout | output | WIDTH (16) | Delayed data output |

## Verification
A set stage that loads the wrong value, or loads on the wrong cycle, shows up at `dout` as a wrong word exactly k strobes later. A disabled register that drifts, or an isolation that leaks, shows up either on the same cycle as a corrupted bypass word or when that stage is re-enabled without a strobe. The bench runs every one of the 256 masks of the default line with fresh data. It compares the output against the arithmetic k-strobe delay, starting from the exact strobe where the new delay must hold. That catches settling that is one strobe late as well as wrong positions in the chain.

// File: rtl/dlp_pkg.sv
`timescale 1ns/1ps
package dlp_pkg;

    localparam int DLP_STAGES_DEF = 8;
    localparam int DLP_WIDTH_DEF  = 16;

    // Path choice of one stage
    typedef enum logic {
        ROUTE_BYPASS = 1'b0,
        ROUTE_REG    = 1'b1
    } route_e;

    // Clock enable of a stage register: strobe and register path chosen
    function automatic logic stage_load(input logic strobe, input route_e r);
        return strobe && (r == ROUTE_REG);
    endfunction

endpackage

// File: rtl/dlp_demux.sv
`timescale 1ns/1ps
module dlp_demux
    import dlp_pkg::*;
#(
    parameter int WIDTH = DLP_WIDTH_DEF
) (
    input  route_e             route,
    input  logic [WIDTH-1:0]   d,
    output logic [WIDTH-1:0]   to_reg,
    output logic [WIDTH-1:0]   bypass
);

    typedef struct packed {
        logic [WIDTH-1:0] to_reg;
        logic [WIDTH-1:0] bypass;
    } split_t;

    split_t split;

    always_comb begin
        split = '0;
        if (route == ROUTE_REG) split.to_reg = d;
        else                    split.bypass = d;
    end

    assign to_reg = split.to_reg;
    assign bypass = split.bypass;

endmodule

// File: rtl/dlp_stage.sv
`timescale 1ns/1ps
module dlp_stage
    import dlp_pkg::*;
#(
    parameter int WIDTH = DLP_WIDTH_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               sel,
    input  logic [WIDTH-1:0]   d,
    output logic [WIDTH-1:0]   q
);

    route_e           route;
    logic [WIDTH-1:0] to_reg;
    logic [WIDTH-1:0] bypass;
    logic [WIDTH-1:0] reg_q;
    logic [WIDTH-1:0] reg_iso;
    logic             load;

    assign route = route_e'(sel);
    assign load  = stage_load(en, route);

    dlp_demux #(.WIDTH(WIDTH)) u_split (
        .route  (route),
        .d      (d),
        .to_reg (to_reg),
        .bypass (bypass)
    );

    // Stage register with clock enable standing in for a gated clock
    always_ff @(posedge clk) begin
        if (rst)       reg_q <= '0;
        else if (load) reg_q <= to_reg;
    end

    // Isolation of an unused register from the path
    assign reg_iso = (route == ROUTE_REG) ? reg_q : '0;

    // Output multiplexer
    assign q = (route == ROUTE_REG) ? reg_iso : bypass;

    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (q == d));

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (sel && en) |=> (reg_q == $past(d)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(reg_q));

    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(reg_q));

endmodule

// File: rtl/dlp_delay_line.sv
`timescale 1ns/1ps
module dlp_delay_line
    import dlp_pkg::*;
#(
    parameter int STAGES = DLP_STAGES_DEF,
    parameter int WIDTH  = DLP_WIDTH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [STAGES-1:0]   sel_mask,
    input  logic [WIDTH-1:0]    din,
    output logic [WIDTH-1:0]    dout
);

    localparam int LINKS = STAGES + 1;

    logic [WIDTH-1:0] link [LINKS];

    assign link[0] = din;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        dlp_stage #(.WIDTH(WIDTH)) u_stage (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .sel (sel_mask[g]),
            .d   (link[g]),
            .q   (link[g+1])
        );
    end

    assign dout = link[STAGES];

    p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0) |-> (dout == din));

endmodule

// File: tb/sim_dlp_delay_line.sv
`timescale 1ns/1ps
module sim_dlp_delay_line;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic [7:0]  sel_mask;
    logic [15:0] din;
    logic [15:0] dout;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [15:0] past [1:8];
    logic [15:0] seed = 16'h1D2B;

    always #10 clk = ~clk;

    dlp_delay_line u0 (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sel_mask (sel_mask),
        .din      (din),
        .dout     (dout)
    );

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s sel=%h actual=%h expected=%h", rq, sel_mask, act, exp);
        end
    endtask

    function automatic logic [15:0] next_val(input logic [15:0] s);
        return s * 16'd25173 + 16'd13849;
    endfunction

    // One strobe with a given value, driven at a falling edge
    task automatic strobe(input logic [15:0] v);
        @(negedge clk);
        din = v;
        en  = 1'b1;
        @(posedge clk);
        #1;
        en  = 1'b0;
    endtask

    // Sweep one mask: R5 steady state, R8 first exact strobe
    task automatic run_mask(input logic [7:0] c);
        int k;
        int cnt;
        k   = $countones(c);
        cnt = 0;
        @(negedge clk);
        sel_mask = c;
        for (int s = 0; s < 10; s++) begin
            if (s > 0) @(negedge clk);
            seed = next_val(seed);
            din  = seed;
            en   = 1'b1;
            #1;
            if (cnt >= k) begin
                if (cnt == k) chk("R8", dout, (k == 0) ? din : past[k]);
                else          chk("R5", dout, (k == 0) ? din : past[k]);
            end
            @(posedge clk);
            for (int j = 8; j > 1; j--) past[j] = past[j-1];
            past[1] = din;
            cnt++;
        end
        #1;
        en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; sel_mask = '0; din = '0;
        for (int j = 1; j <= 8; j++) past[j] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: registers cleared by reset
        sel_mask = 8'hFF;
        #1 chk("R7", dout, 16'h0000);

        // R1: all clear is a combinational path
        @(negedge clk);
        sel_mask = 8'h00;
        din = 16'h1234;
        #1 chk("R1", dout, 16'h1234);
        din = 16'hBEEF;
        #1 chk("R1", dout, 16'hBEEF);

        // R3: single stage loads on a strobe
        @(negedge clk);
        sel_mask = 8'h01;
        strobe(16'hA5A5);
        @(negedge clk);
        din = 16'h0000;
        #1 chk("R3", dout, 16'hA5A5);

        // R4: disabled stage keeps its value while strobes run
        @(negedge clk);
        sel_mask = 8'h00;
        strobe(16'h1111);
        strobe(16'h2222);
        @(negedge clk);
        sel_mask = 8'h01;
        #1 chk("R4", dout, 16'hA5A5);

        // R6: no strobe, output frozen while din moves
        @(negedge clk);
        sel_mask = 8'h80;
        strobe(16'h5555);
        @(negedge clk);
        din = 16'h9999;
        #1 chk("R6", dout, 16'h5555);
        @(negedge clk);
        din = 16'h7777;
        #1 chk("R6", dout, 16'h5555);

        // R2: last stage bypassed gives seven strobes of delay
        @(negedge clk);
        sel_mask = 8'h7F;
        for (int j = 0; j < 7; j++) strobe(16'h0100 + 16'(j));
        @(negedge clk);
        din = 16'hFFFF;
        #1 chk("R2", dout, 16'h0100);

        // R5 and R8: every mask
        for (int c = 0; c < 256; c++) run_mask(8'(c));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule